// File: doc/BRIEF.md
# Shift and Rotate Unit

A combinational shift and rotate unit for the execute stage of a CPU that keeps N, Z, V and C condition codes. It takes an operand, an operand size (8, 16 or 32 bits), an operation code, a distance select (one or two positions) and the current carry flag. It returns the shifted or rotated value along with a new set of the four flags.

There are eight operations: logical shift left and right, arithmetic shift left and right, plain rotate left and right, and rotate left and right through the carry flag. Each operation has its own rule for C and V. The register file, instruction decode and the flag register are outside this block. The unit is built from a one-position step, and the step is chained. A two-position operation is therefore two one-position steps in sequence, including the carry that passes between them.

Top module: `sru_shift_rot`

## Requirements
- R1: `size_i` selects the operand width: 0 is 8 bits, 1 is 16 bits, 2 is 32 bits, and 3 acts as 32 bits. Operand bits above the selected width are ignored. Result bits above the selected width are zero.
- R2: `dist_two_i` = 0 moves the operand by one position. `dist_two_i` = 1 moves it by two positions, and C and V then describe both steps taken together.
- R3: Operation 0 is a logical left shift. Zeros enter at bit 0, C is the last bit shifted out of the top of the width, and V is 0.
- R4: Operation 1 is a logical right shift. Zeros enter at the top of the width, C is the last bit shifted out of bit 0, and V is 0.
- R5: Operation 2 is an arithmetic left shift. C is the last bit shifted out of the top. V is 1 when any bit that passes through the sign position differs from the final sign bit, which means the top two bits (one position) or the top three bits (two positions) are not all equal. Only this operation can set V.
- R6: Operation 3 is an arithmetic right shift. The sign bit stays in place and is copied into every vacated upper position. C is the last bit shifted out of bit 0, and V is 0.
- R7: Operations 4 and 5 rotate left and right within the width. The bit that wraps around is also copied into C, so after the last step C is the new bit 0 (left) or the new top bit (right). V is 0.
- R8: Operations 6 and 7 rotate left and right through carry. The old C enters bit 0 (left) or the top bit (right), and the bit that leaves becomes the new C. A distance of two repeats this rotation. V is 0.
- R9: N is the top bit of the result at the selected width. Z is 1 exactly when every result bit within the width is 0.
- R10: For operations 0 to 5, `carry_i` has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| operand_i | input | 32 | Value to be shifted or rotated |
| size_i | input | 2 | Operand width select (0 byte, 1 word, 2 and 3 long) |
| op_i | input | 3 | Operation code 0 to 7; bit 0 set means rightward |
| dist_two_i | input | 1 | 0 moves one position, 1 moves two positions |
| carry_i | input | 1 | Incoming carry flag |
| result_o | output | 32 | Result, zero above the selected width |
| flag_n_o | output | 1 | Negative flag |
| flag_z_o | output | 1 | Zero flag |
| flag_v_o | output | 1 | Overflow flag |
| flag_c_o | output | 1 | Carry flag |

## Verification
The unit has no registers, so every output is due in the same cycle as the inputs that produce it, with zero cycles of latency. The driver changes the inputs 1 ns after a rising edge and queues the expected result and flags. The monitor takes one item from the queue at the following falling edge, when the logic has settled, and compares it there. This way each comparison covers exactly one stimulus.

// File: rtl/sru_pkg.sv
package sru_pkg;

  localparam int SRU_DW    = 32;
  localparam int SRU_IDX_W = $clog2(SRU_DW);
  localparam int SRU_STEPS = 2;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_WORD = 2'd1,
    SZ_LONG = 2'd2,
    SZ_RSVD = 2'd3
  } sru_size_e;

  // bit 0 of the code is the direction: 0 left, 1 right
  typedef enum logic [2:0] {
    OP_LSL = 3'd0,
    OP_LSR = 3'd1,
    OP_ASL = 3'd2,
    OP_ASR = 3'd3,
    OP_ROL = 3'd4,
    OP_ROR = 3'd5,
    OP_RCL = 3'd6,
    OP_RCR = 3'd7
  } sru_op_e;

  // index of the sign bit for a given size
  function automatic logic [SRU_IDX_W-1:0] top_bit(sru_size_e s);
    case (s)
      SZ_BYTE: top_bit = SRU_IDX_W'(7);
      SZ_WORD: top_bit = SRU_IDX_W'(15);
      default: top_bit = SRU_IDX_W'(SRU_DW - 1);
    endcase
  endfunction

  // ones on every bit that belongs to the selected size
  function automatic logic [SRU_DW-1:0] size_mask(sru_size_e s);
    case (s)
      SZ_BYTE: size_mask = {{(SRU_DW-8){1'b0}}, 8'hFF};
      SZ_WORD: size_mask = {{(SRU_DW-16){1'b0}}, 16'hFFFF};
      default: size_mask = {SRU_DW{1'b1}};
    endcase
  endfunction

  function automatic logic [SRU_DW-1:0] one_hot_at(logic [SRU_IDX_W-1:0] i);
    one_hot_at = {{(SRU_DW-1){1'b0}}, 1'b1} << i;
  endfunction

endpackage

// File: rtl/sru_step.sv
module sru_step
  import sru_pkg::*;
(
  input  sru_size_e          size_i,
  input  sru_op_e            op_i,
  input  logic [SRU_DW-1:0]  val_i,
  input  logic               c_i,
  output logic [SRU_DW-1:0]  val_o,
  output logic               c_o,
  output logic               v_o
);

  logic [SRU_IDX_W-1:0] msb_idx;
  logic [SRU_DW-1:0]    wmask;
  logic                 sign_bit;
  logic                 below_sign;
  logic                 fill_bit;

  always_comb begin
    msb_idx    = top_bit(size_i);
    wmask      = size_mask(size_i);
    sign_bit   = val_i[msb_idx];
    below_sign = val_i[msb_idx - 1'b1];
    fill_bit   = 1'b0;
    val_o      = '0;
    c_o        = 1'b0;
    v_o        = 1'b0;
    if (!op_i[0]) begin
      // leftward: the bit leaving is the sign bit
      case (op_i)
        OP_ROL:  fill_bit = sign_bit;
        OP_RCL:  fill_bit = c_i;
        default: fill_bit = 1'b0;
      endcase
      val_o = ((val_i << 1) & wmask) | {{(SRU_DW-1){1'b0}}, fill_bit};
      c_o   = sign_bit;
      v_o   = (op_i == OP_ASL) && (sign_bit != below_sign);
    end else begin
      // rightward: the bit leaving is bit 0
      case (op_i)
        OP_ASR:  fill_bit = sign_bit;
        OP_ROR:  fill_bit = val_i[0];
        OP_RCR:  fill_bit = c_i;
        default: fill_bit = 1'b0;
      endcase
      val_o = (val_i >> 1) | (fill_bit ? one_hot_at(msb_idx) : '0);
      c_o   = val_i[0];
      v_o   = 1'b0;
    end
  end

endmodule

// File: rtl/sru_flags.sv
module sru_flags
  import sru_pkg::*;
(
  input  sru_size_e          size_i,
  input  logic [SRU_DW-1:0]  res_i,
  output logic               n_o,
  output logic               z_o
);

  always_comb begin
    n_o = res_i[top_bit(size_i)];
    z_o = ((res_i & size_mask(size_i)) == '0);
  end

endmodule

// File: rtl/sru_shift_rot.sv
module sru_shift_rot
  import sru_pkg::*;
(
  input  logic [31:0] operand_i,
  input  logic [1:0]  size_i,
  input  logic [2:0]  op_i,
  input  logic        dist_two_i,
  input  logic        carry_i,
  output logic [31:0] result_o,
  output logic        flag_n_o,
  output logic        flag_z_o,
  output logic        flag_v_o,
  output logic        flag_c_o
);

  localparam int SEL_W = $clog2(SRU_STEPS + 1);

  sru_size_e         size_e;
  sru_op_e           op_e;
  logic [SRU_DW-1:0] stage_val [0:SRU_STEPS];
  logic              stage_c   [0:SRU_STEPS];
  logic              stage_v   [0:SRU_STEPS-1];
  logic [SEL_W-1:0]  dist_sel;
  logic [SRU_DW-1:0] masked_in;
  logic              v_any;

  assign size_e    = sru_size_e'(size_i);
  assign op_e      = sru_op_e'(op_i);
  assign masked_in = operand_i & size_mask(size_e);
  assign dist_sel  = dist_two_i ? SEL_W'(2) : SEL_W'(1);

  assign stage_val[0] = masked_in;
  assign stage_c[0]   = carry_i;

  generate
    for (genvar g = 0; g < SRU_STEPS; g++) begin : g_step
      sru_step u_step (
        .size_i (size_e),
        .op_i   (op_e),
        .val_i  (stage_val[g]),
        .c_i    (stage_c[g]),
        .val_o  (stage_val[g+1]),
        .c_o    (stage_c[g+1]),
        .v_o    (stage_v[g])
      );
    end
  endgenerate

  always_comb begin
    v_any = 1'b0;
    for (int k = 0; k < SRU_STEPS; k++) begin
      if (k < int'(dist_sel)) v_any = v_any | stage_v[k];
    end
  end

  assign result_o = stage_val[dist_sel];
  assign flag_c_o = stage_c[dist_sel];
  assign flag_v_o = v_any;

  sru_flags u_flags (
    .size_i (size_e),
    .res_i  (result_o),
    .n_o    (flag_n_o),
    .z_o    (flag_z_o)
  );

  always_comb begin
    AST_HIGH_BITS_CLEAR: assert ((result_o & ~size_mask(size_e)) == '0); // R1
    AST_V_ONLY_ASL: assert ((op_e == OP_ASL) || !flag_v_o); // R5
    AST_ASR_KEEPS_SIGN: assert ((op_e != OP_ASR) ||
      (result_o[top_bit(size_e)] == masked_in[top_bit(size_e)])); // R6
    AST_ROT_KEEPS_ONES: assert (!(op_e inside {OP_ROL, OP_ROR}) ||
      ($countones(result_o) == $countones(masked_in))); // R7
    AST_RC_KEEPS_ONES: assert (!(op_e inside {OP_RCL, OP_RCR}) ||
      (($countones(result_o) + int'(flag_c_o)) ==
       ($countones(masked_in) + int'(carry_i)))); // R8
    AST_Z_EXCLUDES_N: assert (!(flag_z_o && flag_n_o)); // R9
  end

endmodule

// File: tb/sru_shift_rot_tb.sv
module sru_shift_rot_tb;

  typedef struct {
    logic [31:0] res;
    logic        n;
    logic        z;
    logic        v;
    logic        c;
    string       tag;
  } exp_t;

  logic        clk;
  logic        rst;
  logic [31:0] operand;
  logic [1:0]  size;
  logic [2:0]  op;
  logic        dist_two;
  logic        carry;
  logic [31:0] result;
  logic        fn, fz, fv, fc;

  int   n_checks;
  int   n_fail;
  bit   finished;
  exp_t sb_q[$];

  sru_shift_rot u_dut (
    .operand_i  (operand),
    .size_i     (size),
    .op_i       (op),
    .dist_two_i (dist_two),
    .carry_i    (carry),
    .result_o   (result),
    .flag_n_o   (fn),
    .flag_z_o   (fz),
    .flag_v_o   (fv),
    .flag_c_o   (fc)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // reference built on whole-width rotations instead of single steps
  function automatic exp_t model(int opc, int szc, int d, logic [31:0] x, logic cin);
    exp_t        e;
    int          w;
    int          w1;
    logic [63:0] m, m1, xv, ext, r, t;
    w  = (szc == 0) ? 8 : (szc == 1) ? 16 : 32;
    w1 = w + 1;
    m  = (64'd1 << w) - 64'd1;
    m1 = (64'd1 << w1) - 64'd1;
    xv = {32'd0, x} & m;
    e.v = 1'b0;
    r = 64'd0;
    e.c = 1'b0;
    case (opc)
      0, 2: begin
        r = (xv << d) & m; e.c = xv[w-d];
        if (opc == 2) begin
          t = (xv >> (w - 1 - d)) & ((64'd1 << (d + 1)) - 64'd1);
          e.v = (t != 64'd0) && (t != ((64'd1 << (d + 1)) - 64'd1));
        end
      end
      1: begin r = xv >> d; e.c = xv[d-1]; end
      3: begin
        r = xv >> d;
        if (xv[w-1]) r = r | (m & ~(m >> d));
        e.c = xv[d-1];
      end
      4: begin r = ((xv << d) | (xv >> (w - d))) & m; e.c = r[0]; end
      5: begin r = ((xv >> d) | (xv << (w - d))) & m; e.c = r[w-1]; end
      6: begin
        ext = xv | ({63'd0, cin} << w);
        t = ((ext << d) | (ext >> (w1 - d))) & m1;
        r = t & m; e.c = t[w];
      end
      default: begin
        ext = xv | ({63'd0, cin} << w);
        t = ((ext >> d) | (ext << (w1 - d))) & m1;
        r = t & m; e.c = t[w];
      end
    endcase
    e.res = r[31:0];
    e.n   = r[w-1];
    e.z   = (r == 64'd0);
    case (opc)
      0: e.tag = "R3";
      1: e.tag = "R4";
      2: e.tag = "R5";
      3: e.tag = "R6";
      4, 5: e.tag = "R7";
      default: e.tag = "R8";
    endcase
    if (d == 2) e.tag = {e.tag, "+R2"};
    if (szc != 2) e.tag = {e.tag, "+R1"};
    if (opc < 6 && cin) e.tag = {e.tag, "+R10"};
    return e;
  endfunction

  task automatic apply(int opc, int szc, int d, logic [31:0] x, logic cin);
    exp_t e;
    @(posedge clk);
    #1;
    operand  = x;
    size     = 2'(szc);
    op       = 3'(opc);
    dist_two = (d == 2);
    carry    = cin;
    e = model(opc, (szc == 3) ? 2 : szc, d, x, cin);
    if (szc == 3) e.tag = {e.tag, "+R1"};
    sb_q.push_back(e);
  endtask

  task automatic check1(string what, string tag, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h (op %0d size %0d two %0b x %h cin %0b)",
               tag, what, act, exp, op, size, dist_two, operand, carry);
    end
  endtask

  // monitor: results are due in the same cycle, sampled at the falling edge
  always @(negedge clk) begin
    if (!rst && sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      check1("result", e.tag, result, e.res);
      check1("C", e.tag, {31'd0, fc}, {31'd0, e.c});
      check1("V", e.tag, {31'd0, fv}, {31'd0, e.v});
      check1("N", {e.tag, "+R9"}, {31'd0, fn}, {31'd0, e.n});
      check1("Z", {e.tag, "+R9"}, {31'd0, fz}, {31'd0, e.z});
    end
  end

  initial begin
    logic [31:0] pats [12];
    pats[0]  = 32'h0000_0000; pats[1]  = 32'hFFFF_FFFF;
    pats[2]  = 32'h5555_5555; pats[3]  = 32'hAAAA_AAAA;
    pats[4]  = 32'h8000_8080; pats[5]  = 32'h4000_4040;
    pats[6]  = 32'hC000_C0C0; pats[7]  = 32'h2000_2020;
    pats[8]  = 32'h1234_5678; pats[9]  = 32'h7FFF_7F7F;
    pats[10] = 32'h0001_0001; pats[11] = 32'hA5C3_5A3C;
    n_checks = 0; n_fail = 0; finished = 0;
    rst = 1'b1;
    operand = '0; size = '0; op = '0; dist_two = 1'b0; carry = 1'b0;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    // state from all-zero inputs: zero result, Z set (R9)
    apply(0, 0, 1, 32'h0, 1'b0);
    for (int o = 0; o < 8; o++)
      for (int s = 0; s < 3; s++)
        for (int d = 1; d <= 2; d++)
          for (int p = 0; p < 12; p++)
            for (int ci = 0; ci < 2; ci++)
              apply(o, s, d, pats[p], 1'(ci));
    // reserved size code behaves as 32 bits (R1)
    for (int o = 0; o < 8; o++) begin
      apply(o, 3, 1, 32'hC000_0001, 1'b1);
      apply(o, 3, 2, 32'h9000_0002, 1'b0);
    end
    @(posedge clk);
    @(negedge clk);
    @(negedge clk);
    finished = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #(1_500_000ns);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

endmodule